// File: doc/BRIEF.md
# Interrupt Acknowledge Arbiter

This block sits in a peripheral that shares a backplane with other interrupt sources. The backplane offers four priority request lines, numbered 4 to 7. It also carries one acknowledge signal that is daisy-chained from slot to slot. The block latches the device's internal interrupt request and drives the request line of the configured priority. It then decides whether the next acknowledge belongs to this device or to one further down the chain.

The decision is not taken when the acknowledge arrives. It is taken on the rising edge of the processor's read strobe. The processor raises that strobe, with sync negated, well ahead of the acknowledge. Because of this lead time, the ownership flag has settled long before it is used. The incoming acknowledge is only gated by the flag, so no metastable value can leak to the outgoing acknowledge.

When the device owns the acknowledge, it raises reply. It also raises a select that tells the register read path to place the vector on the data bus in place of register contents. It withdraws its own request at the same time. All bus inputs pass through a configurable synchronizer into the block clock.

Top module: `irq_ack_ctrl`

## Requirements
- R1: While a request is latched and not being served, `tx_irq_o` is one-hot: bit `prio_lvl_i` is set, and bit i stands for backplane level 4+i. With no latched request, `tx_irq_o` is zero.
- R2: On every synchronized rising edge of the read strobe, the ownership flag is resampled. By default this includes ordinary reads with sync asserted. The flag becomes 1 only if a request is latched and no `rx_irq_i` bit strictly above `prio_lvl_i` is set. Otherwise it becomes 0.
- R3: `tx_ack_o` equals the synchronized acknowledge-in ANDed with the inverse of the ownership flag. An acknowledge to a non-owning device passes downstream.
- R4: While the device owns the flag and acknowledge-in is high, `tx_reply_o` and `vec_sel_o` are high and `tx_ack_o` is low. Reply and the outgoing acknowledge are never high together.
- R5: Once the device serves an acknowledge, its request latch is cleared and `tx_irq_o` goes to zero.
- R6: `tx_reply_o` and `vec_sel_o` fall when acknowledge-in is negated.
- R7: Bus init clears the ownership flag and the request latch.
- R8: A request that is latched after the strobe edge does not win the acknowledge that follows that edge.
- R9: A request raised while the vector is being read is held. It is driven on `tx_irq_o` after acknowledge-in negates.
- R10: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low reset |
| irq_req_i | input | 1 | Internal interrupt request (pulse or level) |
| prio_lvl_i | input | LVL_W (2) | Configured level code, 0..3 = level 4..7 |
| rx_irq_i | input | NUM_LEVELS (4) | Received request lines, bit i = level 4+i |
| rx_rd_i | input | 1 | Received read strobe |
| rx_sync_i | input | 1 | Received sync |
| rx_ack_i | input | 1 | Received acknowledge-in |
| rx_init_i | input | 1 | Received bus init |
| tx_irq_o | output | NUM_LEVELS (4) | Transmitted request line, one-hot |
| tx_ack_o | output | 1 | Transmitted acknowledge-out |
| tx_reply_o | output | 1 | Transmitted reply |
| vec_sel_o | output | 1 | Select vector on the register read path |

## Verification
The hardest case to reach is a request that becomes latched between the strobe edge and the acknowledge. Each of those signals looks correct alone, yet the device must let the acknowledge pass. The bench reaches this by raising the strobe first and letting it pass the synchronizer. Only then does it pulse the request and raise the acknowledge. A second hard case is a new request during the vector read. The bench pulses the request while reply is high and checks that the request line stays quiet until the acknowledge drops.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

   // Backplane inputs that cross into the block clock together
   typedef struct packed {
      logic init;
      logic rd;
      logic syn;
      logic ack;
   } bus_in_t;

   localparam int BUS_IN_W = $bits(bus_in_t);

endpackage

// File: rtl/irq_ack_sync.sv
module irq_ack_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES == 0) begin : g_bypass
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign q_o = d_i;
   end else begin : g_chain
      logic [W-1:0] stg_q [STAGES];
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
         end else begin
            stg_q[0] <= d_i;
            for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
         end
      end
      assign q_o = stg_q[STAGES-1];
   end

endmodule

// File: rtl/irq_ack_prio.sv
module irq_ack_prio #(
   parameter int NUM_LEVELS = 4,
   parameter int LVL_W      = 2
) (
   input  logic [LVL_W-1:0]      lvl_i,
   input  logic [NUM_LEVELS-1:0] rx_irq_i,
   input  logic                  req_i,
   output logic                  higher_o,
   output logic [NUM_LEVELS-1:0] tx_irq_o
);

   logic [NUM_LEVELS-1:0] above_mask;

   for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
      assign above_mask[g] = ({1'b0, lvl_i} < (LVL_W+1)'(g));
      assign tx_irq_o[g]   = req_i && (lvl_i == LVL_W'(g));
   end

   assign higher_o = |(rx_irq_i & above_mask);

endmodule

// File: rtl/irq_ack_owner.sv
module irq_ack_owner #(
   parameter bit QUALIFY_SYNC = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic init_i,
   input  logic rd_i,
   input  logic syn_i,
   input  logic ack_i,
   input  logic dev_req_i,
   input  logic higher_i,
   output logic req_o,
   output logic mine_o,
   output logic serving_o
);

   logic rd_d_q;
   logic mine_q;
   logic req_q;
   logic pend_q;
   logic rd_rise;
   logic sample;
   logic serving;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rd_d_q <= 1'b0;
      else         rd_d_q <= rd_i;
   end

   assign rd_rise = rd_i && !rd_d_q;

   if (QUALIFY_SYNC) begin : g_qual
      assign sample = rd_rise && !syn_i;
   end else begin : g_any
      logic unused_syn;
      assign unused_syn = syn_i;
      assign sample = rd_rise;
   end

   assign serving = mine_q && ack_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mine_q <= 1'b0;
         req_q  <= 1'b0;
         pend_q <= 1'b0;
      end else if (init_i) begin
         mine_q <= 1'b0;
         req_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (sample) mine_q <= req_q && !higher_i;
         if (serving) begin
            req_q <= 1'b0;
            if (dev_req_i) pend_q <= 1'b1;
         end else begin
            if (dev_req_i || pend_q) req_q <= 1'b1;
            pend_q <= 1'b0;
         end
      end
   end

   assign req_o     = req_q && !serving;
   assign mine_o    = mine_q;
   assign serving_o = serving;

endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
   import irq_ack_pkg::*;
#(
   parameter int NUM_LEVELS   = 4,
   parameter int SYNC_STAGES  = 2,
   parameter bit QUALIFY_SYNC = 1'b0,
   localparam int LVL_W       = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  irq_req_i,
   input  logic [LVL_W-1:0]      prio_lvl_i,
   input  logic [NUM_LEVELS-1:0] rx_irq_i,
   input  logic                  rx_rd_i,
   input  logic                  rx_sync_i,
   input  logic                  rx_ack_i,
   input  logic                  rx_init_i,
   output logic [NUM_LEVELS-1:0] tx_irq_o,
   output logic                  tx_ack_o,
   output logic                  tx_reply_o,
   output logic                  vec_sel_o
);

   if (NUM_LEVELS < 2 || (1 << LVL_W) != NUM_LEVELS) begin : g_bad_levels
      $error("NUM_LEVELS must be a power of two, at least 2");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 0..4");
   end

   bus_in_t bus_raw;
   bus_in_t bus_s;
   logic    init_s, rd_s, sync_s, ack_s;
   logic    higher_w, req_w, mine_w, serving_w;

   assign bus_raw = '{init: rx_init_i, rd: rx_rd_i, syn: rx_sync_i, ack: rx_ack_i};

   irq_ack_sync #(
      .W      (BUS_IN_W),
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (bus_raw),
      .q_o    (bus_s)
   );

   assign init_s = bus_s.init;
   assign rd_s   = bus_s.rd;
   assign sync_s = bus_s.syn;
   assign ack_s  = bus_s.ack;

   irq_ack_prio #(
      .NUM_LEVELS (NUM_LEVELS),
      .LVL_W      (LVL_W)
   ) prio_i (
      .lvl_i    (prio_lvl_i),
      .rx_irq_i (rx_irq_i),
      .req_i    (req_w),
      .higher_o (higher_w),
      .tx_irq_o (tx_irq_o)
   );

   irq_ack_owner #(
      .QUALIFY_SYNC (QUALIFY_SYNC)
   ) owner_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .init_i    (init_s),
      .rd_i      (rd_s),
      .syn_i     (sync_s),
      .ack_i     (ack_s),
      .dev_req_i (irq_req_i),
      .higher_i  (higher_w),
      .req_o     (req_w),
      .mine_o    (mine_w),
      .serving_o (serving_w)
   );

   // Acknowledge is only gated by a flag settled long before it arrives
   assign tx_ack_o   = ack_s && !mine_w;
   assign tx_reply_o = serving_w;
   assign vec_sel_o  = serving_w;

endmodule

// File: rtl/irq_ack_ctrl_chk.sv
module irq_ack_ctrl_chk #(
   parameter int NUM_LEVELS = 4
) (
   input logic                  clk_i,
   input logic                  rst_ni,
   input logic                  init_s,
   input logic                  rd_s,
   input logic                  mine_i,
   input logic [NUM_LEVELS-1:0] tx_irq_o,
   input logic                  tx_ack_o,
   input logic                  tx_reply_o
);

   logic rd_prev_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rd_prev_q <= 1'b0;
      else         rd_prev_q <= rd_s;
   end

   // R1
   irq_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(tx_irq_o));

   // R2
   mine_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(rd_s && !rd_prev_q) && !init_s) |=> $stable(mine_i));

   // R4
   reply_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_reply_o |-> !tx_ack_o);

   // R5
   req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_reply_o |=> (tx_irq_o == '0));

   // R7
   init_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      init_s |=> !mine_i);

endmodule

bind irq_ack_ctrl irq_ack_ctrl_chk #(
   .NUM_LEVELS (NUM_LEVELS)
) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .init_s     (init_s),
   .rd_s       (rd_s),
   .mine_i     (mine_w),
   .tx_irq_o   (tx_irq_o),
   .tx_ack_o   (tx_ack_o),
   .tx_reply_o (tx_reply_o)
);

// File: tb/irq_ack_ctrl_tb_top.sv
module irq_ack_ctrl_tb_top;

   localparam int NL = 4;
   localparam int LW = 2;
   localparam int SETTLE = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          irq_req = 1'b0;
   logic [LW-1:0] lvl = '0;
   logic [NL-1:0] rx_irq = '0;
   logic          rd = 1'b0, syn = 1'b0, ack = 1'b0, init = 1'b0;
   logic [NL-1:0] tx_irq;
   logic          tx_ack, reply, vsel;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_ack_ctrl #(.NUM_LEVELS(NL), .SYNC_STAGES(2)) dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .irq_req_i  (irq_req),
      .prio_lvl_i (lvl),
      .rx_irq_i   (rx_irq),
      .rx_rd_i    (rd),
      .rx_sync_i  (syn),
      .rx_ack_i   (ack),
      .rx_init_i  (init),
      .tx_irq_o   (tx_irq),
      .tx_ack_o   (tx_ack),
      .tx_reply_o (reply),
      .vec_sel_o  (vsel)
   );

   // Vector fields: {level code[1:0], rx lines[3:0], request, expect ownership}
   localparam logic [7:0] VEC [8] = '{
      8'b00_0000_1_1, 8'b00_0010_1_0, 8'b10_0011_1_1, 8'b10_0100_1_1,
      8'b10_1000_1_0, 8'b11_0111_1_1, 8'b01_0000_0_0, 8'b11_0000_0_0
   };

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic bus_init();
      init = 1'b1; step(SETTLE);
      init = 1'b0; step(SETTLE);
   endtask

   task automatic pulse_req();
      irq_req = 1'b1; step(1);
      irq_req = 1'b0; step(SETTLE);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      step(3);
      // R10: outputs after reset
      check(tx_irq == '0 && !tx_ack && !reply && !vsel, "R10 reset",
            int'({tx_irq, tx_ack, reply, vsel}), 0);
      rst_n = 1'b1;
      step(SETTLE);

      // R3: acknowledge to a non-owning device passes through
      ack = 1'b1; step(SETTLE);
      check(tx_ack && !reply, "R3 pass", int'({tx_ack, reply}), 2);
      ack = 1'b0; step(SETTLE);

      // Table-driven ownership decisions
      for (int i = 0; i < 8; i++) begin
         logic [LW-1:0] v_lvl;
         logic [NL-1:0] v_rx;
         logic          v_req, v_own;
         {v_lvl, v_rx, v_req, v_own} = VEC[i];
         bus_init();
         lvl = v_lvl; rx_irq = v_rx;
         if (v_req) pulse_req(); else step(SETTLE);
         // R1
         check(tx_irq == (v_req ? NL'(1) << v_lvl : NL'(0)), "R1 req line",
               int'(tx_irq), v_req ? (1 << v_lvl) : 0);
         rd = 1'b1; step(SETTLE);
         ack = 1'b1; step(SETTLE);
         // R2 / R4
         check(reply == v_own && vsel == v_own, "R2 R4 ownership",
               int'({reply, vsel}), v_own ? 3 : 0);
         // R3
         check(tx_ack == !v_own, "R3 ack out", int'(tx_ack), int'(!v_own));
         if (v_own) check(tx_irq == '0, "R5 req cleared", int'(tx_irq), 0);
         ack = 1'b0; step(SETTLE);
         // R6
         check(!reply && !vsel, "R6 reply removed", int'({reply, vsel}), 0);
         rd = 1'b0; step(SETTLE);
         rx_irq = '0;
      end

      // R7: init after the decision clears ownership and the request latch
      bus_init();
      lvl = 2'd1;
      pulse_req();
      rd = 1'b1; step(SETTLE);
      init = 1'b1; step(SETTLE);
      init = 1'b0; step(SETTLE);
      ack = 1'b1; step(SETTLE);
      check(tx_ack && !reply, "R7 init clears flag", int'({tx_ack, reply}), 2);
      check(tx_irq == '0, "R7 init clears request", int'(tx_irq), 0);
      ack = 1'b0; rd = 1'b0; step(SETTLE);

      // R8: request latched after the strobe edge loses that acknowledge
      bus_init();
      lvl = 2'd2;
      rd = 1'b1; step(SETTLE);
      pulse_req();
      check(tx_irq == 4'b0100, "R8 request driven", int'(tx_irq), 4);
      ack = 1'b1; step(SETTLE);
      check(tx_ack && !reply, "R8 late request passes", int'({tx_ack, reply}), 2);
      ack = 1'b0; rd = 1'b0; step(SETTLE);
      // R2: next strobe picks the request up
      rd = 1'b1; step(SETTLE);
      ack = 1'b1; step(SETTLE);
      check(reply && !tx_ack, "R2 resample wins", int'({tx_ack, reply}), 1);
      // R9: new request during vector read is held
      pulse_req();
      check(tx_irq == '0, "R9 held while serving", int'(tx_irq), 0);
      ack = 1'b0; step(SETTLE);
      check(tx_irq == 4'b0100, "R9 driven after ack", int'(tx_irq), 4);
      rd = 1'b0; step(SETTLE);

      // R2: after the vector read, next strobe clears the flag
      bus_init();
      lvl = 2'd3;
      pulse_req();
      rd = 1'b1; step(SETTLE);
      ack = 1'b1; step(SETTLE);
      check(reply, "R4 owner replies", int'(reply), 1);
      ack = 1'b0; step(SETTLE);
      rd = 1'b0; step(SETTLE);
      rd = 1'b1; step(SETTLE);
      ack = 1'b1; step(SETTLE);
      check(tx_ack && !reply, "R2 flag cleared", int'({tx_ack, reply}), 2);
      ack = 1'b0; rd = 1'b0; step(SETTLE);

      // R2: an ordinary read with sync asserted also samples
      bus_init();
      lvl = 2'd0;
      pulse_req();
      syn = 1'b1; rd = 1'b1; step(SETTLE);
      rd = 1'b0; syn = 1'b0; step(SETTLE);
      ack = 1'b1; step(SETTLE);
      check(reply && !tx_ack, "R2 sync read samples", int'({tx_ack, reply}), 1);
      ack = 1'b0; step(SETTLE);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule